// File: doc/BRIEF.md
# DRAM Row Retirement Sweeper

This block retires a whole DRAM row after a memory error. A trigger arrives with the failing DRAM error address. The sweeper then forms one candidate address for every value of the 5-bit column field held at bits 5:1. It keeps the other bits of the captured address unchanged. Each candidate goes to an external address translator over a request/response port.

A candidate that translates cleanly becomes a page frame number by dropping the 12 page-offset bits. That frame goes to a page-status lookup, also over a request/response port. The sweeper sends a retire command for the frame only when the lookup reports the page as online and not yet poisoned. All other candidates are counted as skipped.

A mode input enables the sweep. With the mode low, a trigger completes at once and issues no requests or commands.

The translation math and the page bookkeeping are outside this block. The block only sequences the candidates and filters them.

Top module: `row_retire_sweeper`

## Requirements
- R1: If `hetero_mode_i` is low when a trigger is accepted, `done_o` pulses on the next cycle. No request or retire command is issued, and both counters read zero.
- R2: With the mode high, exactly 32 translation requests are issued. Their column values run 0, 1, …, 31 in bits 5:1 of `xl_req_addr_o`. All other bits equal `err_addr_i` as captured with the accepted trigger.
- R3: A translation response with `xl_rsp_err_i` high skips that candidate. No status request is made for it, and the sweep moves to the next column.
- R4: For a clean translation, the status request carries `xl_rsp_pa_i` shifted right by 12, which is the page frame number.
- R5: A status response with `st_rsp_online_i` low skips the frame. No retire command is issued for it.
- R6: A status response with `st_rsp_poisoned_i` high skips the frame. An online, unpoisoned frame gets exactly one retire command, and `rt_pfn_o` carries that frame number.
- R7: While `rt_valid_o` is high and `rt_ready_i` is low, `rt_valid_o` stays high and `rt_pfn_o` stays stable.
- R8: The counters reset to zero and are cleared by every accepted trigger. In the `done_o` cycle, `retired_cnt_o` equals the number of retire commands accepted in this sweep, and `retired_cnt_o` plus `skipped_cnt_o` equals 32. Both counters hold their values until the next accepted trigger.
- R9: `busy_o` rises the cycle after an accepted trigger and stays high through the single `done_o` cycle. It falls right after that cycle. A trigger that arrives while `busy_o` is high has no effect.
- R10: At most one of `xl_req_valid_o`, `st_req_valid_o` and `rt_valid_o` is high at a time. None of them is high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| hetero_mode_i | input | 1 | Enables the sweep when high |
| trig_i | input | 1 | Start pulse, taken when idle |
| err_addr_i | input | ADDR_W (48) | Failing DRAM error address |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| xl_req_valid_o | output | 1 | Translation request valid |
| xl_req_ready_i | input | 1 | Translator accepts the request |
| xl_req_addr_o | output | ADDR_W (48) | Candidate DRAM address |
| xl_rsp_valid_i | input | 1 | Translation response valid |
| xl_rsp_err_i | input | 1 | Translation failed |
| xl_rsp_pa_i | input | PA_W (52) | Translated physical address |
| st_req_valid_o | output | 1 | Status lookup request valid |
| st_req_ready_i | input | 1 | Lookup accepts the request |
| st_req_pfn_o | output | PA_W-12 (40) | Page frame to look up |
| st_rsp_valid_i | input | 1 | Status response valid |
| st_rsp_online_i | input | 1 | Page is online |
| st_rsp_poisoned_i | input | 1 | Page is already poisoned |
| rt_valid_o | output | 1 | Retire command valid |
| rt_ready_i | input | 1 | Retire command accepted |
| rt_pfn_o | output | PA_W-12 (40) | Page frame to retire |
| retired_cnt_o | output | 6 | Retire commands issued in the last sweep |
| skipped_cnt_o | output | 6 | Candidates skipped in the last sweep |

## Verification
The sweep is run under four response patterns:
- Every candidate is good and all handshakes are ready at once. This shows the plain 32-step walk and the retire path.
- Translation errors, offline pages and poisoned pages are mixed by column, with random stalls and response delays. This separates the three filters from one another and from the handshake timing.
- Every translation fails. This shows that no status lookup is made after a translation error.
- Every page is already poisoned and the retire port stalls. This shows that the lookup still runs but nothing is retired.

A second trigger with a different address is sent partway through a sweep. It shows that the running sweep keeps its captured address. A trigger with the mode low, sent after a sweep that left non-zero counts, shows both the at-once completion and the clearing of the counters.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_XL_REQ   = 3'd1,
    ST_XL_WAIT  = 3'd2,
    ST_PG_REQ   = 3'd3,
    ST_PG_WAIT  = 3'd4,
    ST_RETIRE   = 3'd5,
    ST_NEXT     = 3'd6,
    ST_DONE     = 3'd7
  } sweep_state_e;

endpackage

// File: rtl/sweep_rst_sync.sv
// Reset synchronizer: the output asserts asynchronously and releases on a clock edge.
module sweep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/sweep_col_walker.sv
// Holds the captured error address and the current column value.
// Produces the candidate address with the column field replaced.
module sweep_col_walker #(
  parameter int ADDR_W  = 48,
  parameter int COL_LSB = 1,
  parameter int COL_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cand_addr_o,
  output logic              last_o
);

  localparam logic [ADDR_W-1:0] COL_ONES = ADDR_W'((64'd1 << COL_W) - 64'd1);
  localparam logic [ADDR_W-1:0] COL_MASK = COL_ONES << COL_LSB;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              base_en, col_en;

  always_comb begin
    base_en = load_i;
    base_d  = addr_i;
    col_en  = load_i | step_i;
    col_d   = load_i ? '0 : col_q + COL_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      col_q <= '0;
    end else if (col_en) begin
      col_q <= col_d;
    end
  end

  assign cand_addr_o = (base_q & ~COL_MASK) | (ADDR_W'(col_q) << COL_LSB);
  assign last_o      = (col_q == {COL_W{1'b1}});

endmodule

// File: rtl/sweep_tally.sv
// Counts retired and skipped candidates for the current sweep.
module sweep_tally #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             clear_i,
  input  logic             inc_retire_i,
  input  logic             inc_skip_i,
  output logic [CNT_W-1:0] retired_o,
  output logic [CNT_W-1:0] skipped_o
);

  logic [CNT_W-1:0] ret_q, ret_d, skp_q, skp_d;
  logic             ret_en, skp_en;

  always_comb begin
    ret_en = clear_i | inc_retire_i;
    skp_en = clear_i | inc_skip_i;
    ret_d  = clear_i ? '0 : ret_q + CNT_W'(1);
    skp_d  = clear_i ? '0 : skp_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ret_q <= '0;
    end else if (ret_en) begin
      ret_q <= ret_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      skp_q <= '0;
    end else if (skp_en) begin
      skp_q <= skp_d;
    end
  end

  assign retired_o = ret_q;
  assign skipped_o = skp_q;

endmodule

// File: rtl/sweep_ctrl.sv
// Sequencing state machine for the row sweep.
module sweep_ctrl
  import sweep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic mode_i,
  input  logic trig_i,
  input  logic xl_req_ready_i,
  input  logic xl_rsp_valid_i,
  input  logic xl_rsp_err_i,
  input  logic st_req_ready_i,
  input  logic st_rsp_valid_i,
  input  logic st_rsp_online_i,
  input  logic st_rsp_poisoned_i,
  input  logic rt_ready_i,
  input  logic col_last_i,
  output logic busy_o,
  output logic done_o,
  output logic xl_req_valid_o,
  output logic st_req_valid_o,
  output logic rt_valid_o,
  output logic start_o,
  output logic step_o,
  output logic cap_pfn_o,
  output logic inc_retire_o,
  output logic inc_skip_o
);

  sweep_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    start_o      = 1'b0;
    step_o       = 1'b0;
    cap_pfn_o    = 1'b0;
    inc_retire_o = 1'b0;
    inc_skip_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          start_o = 1'b1;
          state_d = mode_i ? ST_XL_REQ : ST_DONE;
        end
      end
      ST_XL_REQ: begin
        if (xl_req_ready_i) state_d = ST_XL_WAIT;
      end
      ST_XL_WAIT: begin
        if (xl_rsp_valid_i) begin
          if (xl_rsp_err_i) begin
            inc_skip_o = 1'b1;
            state_d    = ST_NEXT;
          end else begin
            cap_pfn_o  = 1'b1;
            state_d    = ST_PG_REQ;
          end
        end
      end
      ST_PG_REQ: begin
        if (st_req_ready_i) state_d = ST_PG_WAIT;
      end
      ST_PG_WAIT: begin
        if (st_rsp_valid_i) begin
          if (!st_rsp_online_i || st_rsp_poisoned_i) begin
            inc_skip_o = 1'b1;
            state_d    = ST_NEXT;
          end else begin
            state_d    = ST_RETIRE;
          end
        end
      end
      ST_RETIRE: begin
        if (rt_ready_i) begin
          inc_retire_o = 1'b1;
          state_d      = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (col_last_i) begin
          state_d = ST_DONE;
        end else begin
          step_o  = 1'b1;
          state_d = ST_XL_REQ;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = (state_q == ST_DONE);
  assign xl_req_valid_o = (state_q == ST_XL_REQ);
  assign st_req_valid_o = (state_q == ST_PG_REQ);
  assign rt_valid_o     = (state_q == ST_RETIRE);

endmodule

// File: rtl/row_retire_sweeper.sv
module row_retire_sweeper #(
  parameter int ADDR_W     = 48,
  parameter int PA_W       = 52,
  parameter int PAGE_SHIFT = 12,
  parameter int COL_LSB    = 1,
  parameter int COL_W      = 5,
  parameter int NUM_COL    = 1 << COL_W,
  parameter int PFN_W      = PA_W - PAGE_SHIFT,
  parameter int CNT_W      = $clog2(NUM_COL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              hetero_mode_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              xl_req_valid_o,
  input  logic              xl_req_ready_i,
  output logic [ADDR_W-1:0] xl_req_addr_o,
  input  logic              xl_rsp_valid_i,
  input  logic              xl_rsp_err_i,
  input  logic [PA_W-1:0]   xl_rsp_pa_i,
  output logic              st_req_valid_o,
  input  logic              st_req_ready_i,
  output logic [PFN_W-1:0]  st_req_pfn_o,
  input  logic              st_rsp_valid_i,
  input  logic              st_rsp_online_i,
  input  logic              st_rsp_poisoned_i,
  output logic              rt_valid_o,
  input  logic              rt_ready_i,
  output logic [PFN_W-1:0]  rt_pfn_o,
  output logic [CNT_W-1:0]  retired_cnt_o,
  output logic [CNT_W-1:0]  skipped_cnt_o
);

  logic             core_rst_n;
  logic             start, step, cap_pfn, inc_retire, inc_skip, col_last;
  logic [PFN_W-1:0] pfn_q;

  sweep_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (core_rst_n)
  );

  sweep_ctrl u_ctrl (
    .clk_i             (clk_i),
    .rst_n_i           (core_rst_n),
    .mode_i            (hetero_mode_i),
    .trig_i            (trig_i),
    .xl_req_ready_i    (xl_req_ready_i),
    .xl_rsp_valid_i    (xl_rsp_valid_i),
    .xl_rsp_err_i      (xl_rsp_err_i),
    .st_req_ready_i    (st_req_ready_i),
    .st_rsp_valid_i    (st_rsp_valid_i),
    .st_rsp_online_i   (st_rsp_online_i),
    .st_rsp_poisoned_i (st_rsp_poisoned_i),
    .rt_ready_i        (rt_ready_i),
    .col_last_i        (col_last),
    .busy_o            (busy_o),
    .done_o            (done_o),
    .xl_req_valid_o    (xl_req_valid_o),
    .st_req_valid_o    (st_req_valid_o),
    .rt_valid_o        (rt_valid_o),
    .start_o           (start),
    .step_o            (step),
    .cap_pfn_o         (cap_pfn),
    .inc_retire_o      (inc_retire),
    .inc_skip_o        (inc_skip)
  );

  sweep_col_walker #(
    .ADDR_W  (ADDR_W),
    .COL_LSB (COL_LSB),
    .COL_W   (COL_W)
  ) u_walk (
    .clk_i       (clk_i),
    .rst_n_i     (core_rst_n),
    .load_i      (start),
    .addr_i      (err_addr_i),
    .step_i      (step),
    .cand_addr_o (xl_req_addr_o),
    .last_o      (col_last)
  );

  sweep_tally #(.CNT_W(CNT_W)) u_tally (
    .clk_i        (clk_i),
    .rst_n_i      (core_rst_n),
    .clear_i      (start),
    .inc_retire_i (inc_retire),
    .inc_skip_i   (inc_skip),
    .retired_o    (retired_cnt_o),
    .skipped_o    (skipped_cnt_o)
  );

  // Page frame register: the page offset is dropped when the frame is captured.
  always_ff @(posedge clk_i or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pfn_q <= '0;
    end else if (cap_pfn) begin
      pfn_q <= xl_rsp_pa_i[PA_W-1:PAGE_SHIFT];
    end
  end

  assign st_req_pfn_o = pfn_q;
  assign rt_pfn_o     = pfn_q;

endmodule

// File: rtl/sweep_checker.sv
module sweep_checker #(
  parameter int PFN_W   = 40,
  parameter int ADDR_W  = 48,
  parameter int CNT_W   = 6,
  parameter int NUM_COL = 32
) (
  input logic              clk_i,
  input logic              rst_n_i,
  input logic              hetero_mode_i,
  input logic              trig_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              xl_req_valid_o,
  input logic              xl_req_ready_i,
  input logic [ADDR_W-1:0] xl_req_addr_o,
  input logic              st_req_valid_o,
  input logic              st_rsp_valid_i,
  input logic              st_rsp_online_i,
  input logic              st_rsp_poisoned_i,
  input logic              rt_valid_o,
  input logic              rt_ready_i,
  input logic [PFN_W-1:0]  rt_pfn_o,
  input logic [CNT_W-1:0]  retired_cnt_o,
  input logic [CNT_W-1:0]  skipped_cnt_o
);

  a_r1_bypass: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!busy_o && trig_i && !hetero_mode_i) |=>
      (done_o && retired_cnt_o == '0 && skipped_cnt_o == '0));

  a_r9_accept: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!busy_o && trig_i && hetero_mode_i) |=> (busy_o && !done_o && xl_req_valid_o));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |=> (!done_o && !busy_o));

  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (busy_o && !done_o) |=> busy_o);

  a_r7_retire_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rt_valid_o && !rt_ready_i) |=> (rt_valid_o && $stable(rt_pfn_o)));

  a_r2_req_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (xl_req_valid_o && !xl_req_ready_i) |=> (xl_req_valid_o && $stable(xl_req_addr_o)));

  a_r6_retire_cause: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rt_valid_o) |-> $past(st_rsp_valid_i && st_rsp_online_i && !st_rsp_poisoned_i));

  a_r10_one_valid: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $onehot0({xl_req_valid_o, st_req_valid_o, rt_valid_o}));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !busy_o |-> !(xl_req_valid_o || st_req_valid_o || rt_valid_o));

  a_r8_total: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    done_o |-> ((32'(retired_cnt_o) + 32'(skipped_cnt_o) == 32'(NUM_COL)) ||
                (retired_cnt_o == '0 && skipped_cnt_o == '0)));

endmodule

bind row_retire_sweeper sweep_checker #(
  .PFN_W   (PFN_W),
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .NUM_COL (NUM_COL)
) u_sweep_chk (
  .clk_i             (clk_i),
  .rst_n_i           (core_rst_n),
  .hetero_mode_i     (hetero_mode_i),
  .trig_i            (trig_i),
  .busy_o            (busy_o),
  .done_o            (done_o),
  .xl_req_valid_o    (xl_req_valid_o),
  .xl_req_ready_i    (xl_req_ready_i),
  .xl_req_addr_o     (xl_req_addr_o),
  .st_req_valid_o    (st_req_valid_o),
  .st_rsp_valid_i    (st_rsp_valid_i),
  .st_rsp_online_i   (st_rsp_online_i),
  .st_rsp_poisoned_i (st_rsp_poisoned_i),
  .rt_valid_o        (rt_valid_o),
  .rt_ready_i        (rt_ready_i),
  .rt_pfn_o          (rt_pfn_o),
  .retired_cnt_o     (retired_cnt_o),
  .skipped_cnt_o     (skipped_cnt_o)
);

// File: tb/row_retire_sweeper_tb.sv
`timescale 1ns/1ps
module row_retire_sweeper_tb_top;

  localparam int ADDR_W = 48;
  localparam int PA_W   = 52;
  localparam int PFN_W  = 40;

  logic              clk_i = 1'b0;
  logic              rst_n_i;
  logic              hetero_mode_i;
  logic              trig_i;
  logic [ADDR_W-1:0] err_addr_i;
  logic              busy_o, done_o;
  logic              xl_req_valid_o, xl_req_ready_i;
  logic [ADDR_W-1:0] xl_req_addr_o;
  logic              xl_rsp_valid_i, xl_rsp_err_i;
  logic [PA_W-1:0]   xl_rsp_pa_i;
  logic              st_req_valid_o, st_req_ready_i;
  logic [PFN_W-1:0]  st_req_pfn_o;
  logic              st_rsp_valid_i, st_rsp_online_i, st_rsp_poisoned_i;
  logic              rt_valid_o, rt_ready_i;
  logic [PFN_W-1:0]  rt_pfn_o;
  logic [5:0]        retired_cnt_o, skipped_cnt_o;

  always #2.5 clk_i = ~clk_i;

  row_retire_sweeper dut_i (.*);

  int n_total = 0;
  int n_fail  = 0;

  // Reference model state.
  int                scen = 0;
  logic [ADDR_W-1:0] m_base;
  int                m_col, m_phase, m_ret, m_skip, m_st;
  logic [PFN_W-1:0]  m_pfn;
  bit                xl_pend, st_pend, rt_stalled;
  int                xl_wait, st_wait;
  logic [PFN_W-1:0]  rt_prev;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit pol_err(int s, int c);
    return (s == 2) || (s == 1 && (c % 7) == 3);
  endfunction
  function automatic bit pol_online(int s, int c);
    return !(s == 1 && (c % 5) == 2);
  endfunction
  function automatic bit pol_poison(int s, int c);
    return (s == 3) || (s == 1 && (c % 6) == 4);
  endfunction
  function automatic logic [PA_W-1:0] pa_of(int s, int c);
    return 52'h3_1000_0000_0000 | (52'(c) << 14) | (52'(s) << 24) | 52'h0ABC;
  endfunction
  function automatic bit stall_now();
    return (scen != 0) && (($urandom % 3) == 0);
  endfunction

  // Responder and reference model, all on the falling edge.
  initial begin
    xl_req_ready_i = 0; xl_rsp_valid_i = 0; xl_rsp_err_i = 0; xl_rsp_pa_i = '0;
    st_req_ready_i = 0; st_rsp_valid_i = 0; st_rsp_online_i = 0; st_rsp_poisoned_i = 0;
    rt_ready_i = 0; xl_pend = 0; st_pend = 0; rt_stalled = 0;
    forever begin
      @(negedge clk_i);
      if (rst_n_i) begin
        // R10: single outstanding request, quiet while idle
        chk($countones({xl_req_valid_o, st_req_valid_o, rt_valid_o}) <= 1 &&
            (busy_o || !(xl_req_valid_o | st_req_valid_o | rt_valid_o)),
            "R10", "valid outputs", {xl_req_valid_o, st_req_valid_o, rt_valid_o}, 0);
        if (rt_stalled) begin
          chk(rt_valid_o && rt_pfn_o == rt_prev, "R7", "retire hold", rt_pfn_o, rt_prev);
          rt_stalled = 0;
        end
      end
      xl_rsp_valid_i = 0;
      st_rsp_valid_i = 0;
      // translator response
      if (xl_pend) begin
        if (xl_wait == 0) begin
          xl_pend = 0;
          xl_rsp_valid_i = 1;
          xl_rsp_err_i   = pol_err(scen, m_col);
          xl_rsp_pa_i    = pa_of(scen, m_col);
          if (xl_rsp_err_i) begin m_skip++; m_col++; m_phase = 0; end
          else begin m_pfn = xl_rsp_pa_i[PA_W-1:12]; m_phase = 2; end
        end else xl_wait--;
      end
      // status response
      if (st_pend) begin
        if (st_wait == 0) begin
          st_pend = 0;
          st_rsp_valid_i    = 1;
          st_rsp_online_i   = pol_online(scen, m_col);
          st_rsp_poisoned_i = pol_poison(scen, m_col);
          if (!st_rsp_online_i || st_rsp_poisoned_i) begin m_skip++; m_col++; m_phase = 0; end
          else m_phase = 4;
        end else st_wait--;
      end
      // requests
      xl_req_ready_i = xl_req_valid_o && !stall_now();
      if (xl_req_valid_o && xl_req_ready_i) begin
        logic [ADDR_W-1:0] e;
        e = (m_base & ~48'h3E) | (48'(m_col) << 1);
        chk(m_phase == 0 && m_col < 32, "R2", "request order", m_col, m_phase);
        chk(xl_req_addr_o == e, "R2", "candidate address", xl_req_addr_o, e);
        xl_pend = 1; xl_wait = (scen == 0) ? 0 : int'($urandom % 4); m_phase = 1;
      end
      st_req_ready_i = st_req_valid_o && !stall_now();
      if (st_req_valid_o && st_req_ready_i) begin
        chk(m_phase == 2, "R3", "status request allowed", m_phase, 2);
        chk(st_req_pfn_o == m_pfn, "R4", "status frame", st_req_pfn_o, m_pfn);
        m_st++;
        st_pend = 1; st_wait = (scen == 0) ? 0 : int'($urandom % 4); m_phase = 3;
      end
      rt_ready_i = rt_valid_o && !((scen != 0) && (($urandom % 2) == 0));
      if (rt_valid_o && rt_ready_i) begin
        chk(m_phase == 4, "R6", "retire allowed", m_phase, 4);
        chk(rt_pfn_o == m_pfn, "R6", "retire frame", rt_pfn_o, m_pfn);
        m_ret++; m_col++; m_phase = 0;
      end else if (rt_valid_o) begin
        rt_stalled = 1; rt_prev = rt_pfn_o;
      end
    end
  end

  task automatic run_sweep(input int s, input logic [ADDR_W-1:0] addr, input bit poke);
    int exp_ret = 0, exp_skip = 0, exp_st = 0, cyc = 0;
    for (int c = 0; c < 32; c++) begin
      if (pol_err(s, c)) exp_skip++;
      else begin
        exp_st++;
        if (!pol_online(s, c) || pol_poison(s, c)) exp_skip++; else exp_ret++;
      end
    end
    scen = s; m_base = addr; m_col = 0; m_phase = 0; m_ret = 0; m_skip = 0; m_st = 0;
    @(negedge clk_i);
    hetero_mode_i = 1; err_addr_i = addr; trig_i = 1;
    @(negedge clk_i);
    trig_i = 0; err_addr_i = '1;
    chk(busy_o && !done_o, "R9", "busy after trigger", {busy_o, done_o}, 2'b10);
    if (poke) begin
      repeat (30) @(negedge clk_i);
      trig_i = 1; hetero_mode_i = 0; err_addr_i = 48'h1234_5678_9ABC;
      @(negedge clk_i);
      trig_i = 0; hetero_mode_i = 1;
      chk(busy_o && !done_o, "R9", "trigger while busy ignored", {busy_o, done_o}, 2'b10);
    end
    while (!done_o && cyc < 20000) begin @(negedge clk_i); cyc++; end
    chk(done_o, "R9", "done seen", done_o, 1);
    chk(m_col == 32, "R2", "columns walked", m_col, 32);
    chk(m_st == exp_st, "R3", "status lookups", m_st, exp_st);
    chk(m_ret == exp_ret, "R5 R6", "retires issued", m_ret, exp_ret);
    chk(retired_cnt_o == 6'(exp_ret), "R8", "retired count", retired_cnt_o, exp_ret);
    chk(skipped_cnt_o == 6'(exp_skip), "R8", "skipped count", skipped_cnt_o, exp_skip);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R9", "done one cycle", {busy_o, done_o}, 0);
    repeat (3) @(negedge clk_i);
    chk(retired_cnt_o == 6'(exp_ret) && skipped_cnt_o == 6'(exp_skip), "R8", "counts held",
        {retired_cnt_o, skipped_cnt_o}, {6'(exp_ret), 6'(exp_skip)});
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    rst_n_i = 0; hetero_mode_i = 0; trig_i = 0; err_addr_i = '0;
    repeat (4) @(negedge clk_i);
    rst_n_i = 1;
    repeat (4) @(negedge clk_i);
    chk(!busy_o && !done_o && retired_cnt_o == 0 && skipped_cnt_o == 0, "R8",
        "reset state", {busy_o, done_o, retired_cnt_o, skipped_cnt_o}, 0);

    run_sweep(0, 48'hA5A5_5A5A_F03E, 0);
    run_sweep(1, 48'h0F0F_1234_567F, 1);
    // R1: mode off after a sweep that left non-zero counts
    @(negedge clk_i);
    hetero_mode_i = 0; trig_i = 1; err_addr_i = 48'h0000_0000_1000;
    @(negedge clk_i);
    trig_i = 0;
    chk(done_o && busy_o, "R1", "bypass done", {busy_o, done_o}, 2'b11);
    chk(retired_cnt_o == 0 && skipped_cnt_o == 0, "R1", "bypass counts cleared",
        {retired_cnt_o, skipped_cnt_o}, 0);
    chk(!(xl_req_valid_o | st_req_valid_o | rt_valid_o), "R1", "bypass no requests",
        {xl_req_valid_o, st_req_valid_o, rt_valid_o}, 0);
    @(negedge clk_i);
    chk(!done_o && !busy_o, "R1", "bypass ends", {busy_o, done_o}, 0);

    run_sweep(2, 48'h7777_0000_0002, 0);
    run_sweep(3, 48'h0001_FFFF_FFC0, 0);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule